// File: doc/BRIEF.md
# Debug Monitor Event Controller

This block decides when a running core should enter its debug-monitor exception rather than stop. It holds three registers: a halting-control word, a monitor-control word and a sticky debug-status word. The core reaches the monitor-control and status words through a plain register bus. The halting-control word is written only through a separate debug-port write strobe. Event pulses arrive from a breakpoint unit, a watchpoint unit and an instruction-retired strobe. The block turns them into status bits and a level exception request. The request is gated by the monitor enable, by halting debug and by a priority comparison.

The exception sequencer reports two strobes back to the block. `exc_taken` marks handler entry and `exc_return` marks handler exit. While the handler runs, the request is held low. If the handler leaves with the step bit set, the block waits for exactly one retired instruction. It then records a step completion and raises the request again. The block has no streaming data path, so it has no valid/ready handshake. Every pin is a plain control or status signal, sampled on the rising clock edge.

Top module: `dbgmon_ctrl`

## Requirements
- R1: After reset (`rst_n` low), all three registers read zero, `dbg_status` is 0 and `mon_exc_req` is low.
- R2: A debug-port write changes halting-debug enable (address 0, bit 0) only when `dp_wdata[31:16]` equals 0xA05F, and it copies `dp_wdata[0]` into that bit. Core-bus writes to address 0 leave the bit unchanged.
- R3: While halting-debug enable is 1, `mon_exc_req` stays low, including when the pend bit is set, and breakpoint, watchpoint and step events set no status bit.
- R4: The monitor-control word at address 1 holds enable in bit 16, pend in bit 17, step in bit 18 and a software flag in bit 19, and reads back as written. The software flag has no effect on `mon_exc_req`.
- R5: The pend bit raises `mon_exc_req` even when the enable bit is 0. The pend bit clears in the cycle after `exc_taken`.
- R6: `mon_exc_req` can be high only while `mon_prio` is numerically lower than `cur_prio` (unsigned). The comparison acts in the same cycle that the priorities change.
- R7: The status word (address 2, also on `dbg_status`) uses bit 0 for step done, bit 1 for breakpoint and bit 2 for watchpoint. An event pulse sets its bit one edge later when enable is 1 and halting debug is 0. With enable at 1, any set status bit raises `mon_exc_req`.
- R8: Status bits are sticky. A core-bus write to address 2 clears exactly the bits written as 1. A clear that coincides with a new event for the same bit leaves that bit set.
- R9: An `exc_return` while the step bit is 1 arms a single step. The next `instr_retired` sets status bit 0 and raises the request. Retirements while the handler runs, or while no step is armed, set nothing.
- R10: From the cycle after `exc_taken` until `exc_return`, `mon_exc_req` is low even with status bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Core-side register write strobe |
| bus_addr | input | 2 | Register select: 0 halting control, 1 monitor control, 2 status |
| bus_wdata | input | 32 | Core-side write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dp_we | input | 1 | Debug-port write strobe for the halting-control word |
| dp_wdata | input | 32 | Debug-port write data: key in the upper half, enable in bit 0 |
| bkpt_evt | input | 1 | Breakpoint event pulse |
| watch_evt | input | 1 | Watchpoint event pulse |
| instr_retired | input | 1 | One instruction retired this cycle |
| exc_taken | input | 1 | Monitor exception entered |
| exc_return | input | 1 | Monitor handler returned |
| cur_prio | input | PRIO_W | Current execution priority (lower value is more urgent) |
| mon_prio | input | PRIO_W | Programmed monitor group priority |
| mon_exc_req | output | 1 | Debug-monitor exception request, level |
| dbg_status | output | 3 | Sticky status: step done, breakpoint, watchpoint |

## Verification
Register writes and event pulses become visible on `bus_rdata`, `dbg_status` and `mon_exc_req` one rising edge after the cycle that drives them. Priority changes and read-address changes show up within the same cycle, because those paths are combinational over registered state. The driver changes inputs one time unit after a rising edge and queues each expectation in the cycle its result is due. The monitor compares at the following falling edge, before the inputs move again. The single-step sequence is checked at each stage: handler entry, a retirement inside the handler, the return, and the first retirement after it.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [15:0] HALT_KEY = 16'hA05F;

  localparam logic [AW-1:0] A_HALT = 2'd0;
  localparam logic [AW-1:0] A_MON  = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;

  localparam int B_MEN   = 16;
  localparam int B_MPEND = 17;
  localparam int B_MSTEP = 18;
  localparam int B_MFLAG = 19;

  localparam int NUM_EVT = 3;
  localparam int E_STEP  = 0;
  localparam int E_BKPT  = 1;
  localparam int E_WATCH = 2;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HANDLER = 2'd1,
    ST_STEP    = 2'd2
  } step_st_e;
endpackage

// File: rtl/dbgmon_ctl_regs.sv
module dbgmon_ctl_regs
  import dbgmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_we,
  input  logic [DW-1:0] dp_wdata,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          exc_taken,
  output logic          halt_en,
  output logic          mon_en,
  output logic          mon_pend,
  output logic          mon_step,
  output logic          mon_flag
);
  logic key_ok;
  logic mon_wr;

  assign key_ok = (dp_wdata[DW-1:DW-16] == HALT_KEY);
  assign mon_wr = bus_we && (bus_addr == A_MON);

  // halting enable: debug port only, key protected
  always_ff @(posedge clk) begin
    if (!rst_n)               halt_en <= 1'b0;
    else if (dp_we && key_ok) halt_en <= dp_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_en   <= 1'b0;
      mon_step <= 1'b0;
      mon_flag <= 1'b0;
    end else if (mon_wr) begin
      mon_en   <= bus_wdata[B_MEN];
      mon_step <= bus_wdata[B_MSTEP];
      mon_flag <= bus_wdata[B_MFLAG];
    end
  end

  // pend: exception entry clears it, and entry wins over a write
  always_ff @(posedge clk) begin
    if (!rst_n)         mon_pend <= 1'b0;
    else if (exc_taken) mon_pend <= 1'b0;
    else if (mon_wr)    mon_pend <= bus_wdata[B_MPEND];
  end
endmodule

// File: rtl/dbgmon_sticky.sv
module dbgmon_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        bits_o[g] <= 1'b0;
      else if (set_i[g]) bits_o[g] <= 1'b1;   // set beats clear
      else if (clr_i[g]) bits_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgmon_step_fsm.sv
module dbgmon_step_fsm
  import dbgmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_taken,
  input  logic exc_return,
  input  logic step_req,
  input  logic instr_retired,
  output logic in_handler,
  output logic step_done
);
  step_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    step_done = 1'b0;
    unique case (st_q)
      ST_RUN: if (exc_taken) st_d = ST_HANDLER;
      ST_HANDLER: if (exc_return) st_d = step_req ? ST_STEP : ST_RUN;
      ST_STEP: begin
        if (exc_taken) begin
          st_d = ST_HANDLER;
        end else if (instr_retired) begin
          step_done = 1'b1;
          st_d      = ST_RUN;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign in_handler = (st_q == ST_HANDLER);
endmodule

// File: rtl/dbgmon_ctrl.sv
module dbgmon_ctrl
  import dbgmon_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dp_we,
  input  logic [DW-1:0]     dp_wdata,
  input  logic              bkpt_evt,
  input  logic              watch_evt,
  input  logic              instr_retired,
  input  logic              exc_taken,
  input  logic              exc_return,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] mon_prio,
  output logic              mon_exc_req,
  output logic [NUM_EVT-1:0] dbg_status
);
  logic halt_en, mon_en, mon_pend, mon_step, mon_flag;
  logic in_handler, step_done;
  logic evt_gate, prio_ok;
  logic [NUM_EVT-1:0] evt_set, evt_clr;

  dbgmon_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .dp_we(dp_we), .dp_wdata(dp_wdata),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .exc_taken(exc_taken),
    .halt_en(halt_en), .mon_en(mon_en), .mon_pend(mon_pend),
    .mon_step(mon_step), .mon_flag(mon_flag)
  );

  dbgmon_step_fsm u_step (
    .clk(clk), .rst_n(rst_n),
    .exc_taken(exc_taken), .exc_return(exc_return),
    .step_req(mon_step), .instr_retired(instr_retired),
    .in_handler(in_handler), .step_done(step_done)
  );

  // events count only with monitor on and halting debug off
  assign evt_gate         = mon_en && !halt_en;
  assign evt_set[E_STEP]  = evt_gate && step_done;
  assign evt_set[E_BKPT]  = evt_gate && bkpt_evt;
  assign evt_set[E_WATCH] = evt_gate && watch_evt;
  assign evt_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[NUM_EVT-1:0] : '0;

  dbgmon_sticky #(.N(NUM_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_i(evt_set), .clr_i(evt_clr), .bits_o(dbg_status)
  );

  assign prio_ok     = (mon_prio < cur_prio);
  assign mon_exc_req = !halt_en && !in_handler && prio_ok &&
                       (mon_pend || (mon_en && (|dbg_status)));

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_HALT: bus_rdata[0] = halt_en;
      A_MON: begin
        bus_rdata[B_MEN]   = mon_en;
        bus_rdata[B_MPEND] = mon_pend;
        bus_rdata[B_MSTEP] = mon_step;
        bus_rdata[B_MFLAG] = mon_flag;
      end
      A_STAT: bus_rdata[NUM_EVT-1:0] = dbg_status;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbgmon_ctrl_chk.sv
module dbgmon_ctrl_chk
  import dbgmon_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic               bkpt_evt,
  input logic               exc_taken,
  input logic               exc_return,
  input logic [PRIO_W-1:0]  cur_prio,
  input logic [PRIO_W-1:0]  mon_prio,
  input logic               mon_exc_req,
  input logic [NUM_EVT-1:0] dbg_status,
  input logic               halt_en,
  input logic               mon_en,
  input logic               mon_pend,
  input logic               step_done
);
  assert_halt_blocks_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_en |-> !mon_exc_req);

  assert_pend_clears_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> !mon_pend);

  assert_req_needs_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mon_exc_req |-> (mon_prio < cur_prio));

  assert_bkpt_records_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_evt && mon_en && !halt_en) |=> dbg_status[E_BKPT]);

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_stk
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_status[g] && !(bus_we && bus_addr == A_STAT && bus_wdata[g])) |=> dbg_status[g]);
  end

  assert_step_records_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && mon_en && !halt_en) |=> dbg_status[E_STEP]);

  assert_handler_masks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && !exc_return) |=> !mon_exc_req);
endmodule

bind dbgmon_ctrl dbgmon_ctrl_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bkpt_evt(bkpt_evt), .exc_taken(exc_taken), .exc_return(exc_return),
  .cur_prio(cur_prio), .mon_prio(mon_prio),
  .mon_exc_req(mon_exc_req), .dbg_status(dbg_status),
  .halt_en(halt_en), .mon_en(mon_en), .mon_pend(mon_pend),
  .step_done(step_done)
);

// File: tb/sim_dbgmon_ctrl.sv
module sim_dbgmon_ctrl;
  localparam int PW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_we, dp_we, bkpt_evt, watch_evt, instr_retired;
  logic        exc_taken, exc_return, mon_exc_req;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, dp_wdata;
  logic [PW-1:0] cur_prio, mon_prio;
  logic [2:0]  dbg_status;

  dbgmon_ctrl #(.PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_we(dp_we),
    .dp_wdata(dp_wdata), .bkpt_evt(bkpt_evt), .watch_evt(watch_evt),
    .instr_retired(instr_retired), .exc_taken(exc_taken),
    .exc_return(exc_return), .cur_prio(cur_prio), .mon_prio(mon_prio),
    .mon_exc_req(mon_exc_req), .dbg_status(dbg_status)
  );

  typedef struct {
    string       tag;
    int          kind;   // 0 request, 1 status, 2 read data
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // monitor: compares every queued expectation at the falling edge
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        case (it.kind)
          0:       act = {31'b0, mon_exc_req};
          1:       act = {29'b0, dbg_status};
          default: act = bus_rdata;
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_item(string tag, int kind, logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_req(string tag, logic e);      expect_item(tag, 0, {31'b0, e}); endtask
  task automatic chk_stat(string tag, logic [2:0] e); expect_item(tag, 1, {29'b0, e}); endtask
  task automatic chk_rd(string tag, logic [1:0] a, logic [31:0] e);
    bus_addr = a;
    expect_item(tag, 2, e);
  endtask

  task automatic core_wr(logic [1:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic dp_wr(logic [31:0] d);
    dp_we = 1'b1; dp_wdata = d;
    cyc();
    dp_we = 1'b0; dp_wdata = '0;
  endtask

  task automatic pulse(int which);
    case (which)
      0: bkpt_evt = 1'b1;
      1: watch_evt = 1'b1;
      2: instr_retired = 1'b1;
      3: exc_taken = 1'b1;
      default: exc_return = 1'b1;
    endcase
    cyc();
    bkpt_evt = 0; watch_evt = 0; instr_retired = 0; exc_taken = 0; exc_return = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; dp_we = 0; dp_wdata = 0;
    bkpt_evt = 0; watch_evt = 0; instr_retired = 0; exc_taken = 0; exc_return = 0;
    cur_prio = 8'd8; mon_prio = 8'd1;
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // R1 reset state
    chk_req("R1 req", 1'b0);
    chk_stat("R1 status", 3'b000);
    chk_rd("R1 halt reg", 2'd0, 32'h0);
    chk_rd("R1 mon reg", 2'd1, 32'h0);

    // R2 keyed debug-port write
    dp_wr(32'hA05F_0001);
    chk_rd("R2 keyed set", 2'd0, 32'h1);
    dp_wr(32'h1234_0000);
    chk_rd("R2 bad key ignored", 2'd0, 32'h1);
    core_wr(2'd0, 32'hA05F_0000);
    chk_rd("R2 core write ignored", 2'd0, 32'h1);

    // R3 halting debug suppresses monitor
    core_wr(2'd1, 32'h0001_0000);
    pulse(0);
    chk_stat("R3 bkpt ignored", 3'b000);
    chk_req("R3 no req", 1'b0);
    core_wr(2'd1, 32'h0003_0000);
    chk_req("R3 pend blocked", 1'b0);
    core_wr(2'd1, 32'h0001_0000);
    dp_wr(32'hA05F_0000);
    chk_rd("R2 keyed clear", 2'd0, 32'h0);

    // R7 event recording and request
    pulse(0);
    chk_stat("R7 bkpt bit1", 3'b010);
    chk_req("R7 req from status", 1'b1);
    core_wr(2'd2, 32'h1);
    chk_stat("R8 clear other bit", 3'b010);
    core_wr(2'd2, 32'h2);
    chk_stat("R8 w1c clears", 3'b000);
    chk_req("R8 req drops", 1'b0);
    pulse(1);
    chk_rd("R7 watch bit2 read", 2'd2, 32'h4);
    // R8 clear and event in same cycle
    bus_we = 1; bus_addr = 2'd2; bus_wdata = 32'h4; watch_evt = 1;
    cyc();
    bus_we = 0; bus_wdata = 0; watch_evt = 0;
    chk_stat("R8 set beats clear", 3'b100);
    core_wr(2'd2, 32'h7);
    chk_stat("R8 all cleared", 3'b000);

    // R6 priority gating
    mon_prio = 8'd5; cur_prio = 8'd5;
    pulse(0);
    chk_stat("R6 bkpt recorded", 3'b010);
    chk_req("R6 equal prio blocks", 1'b0);
    cur_prio = 8'd6;
    chk_req("R6 higher monitor prio", 1'b1);
    cur_prio = 8'd4;
    chk_req("R6 lower monitor prio", 1'b0);
    cur_prio = 8'd8; mon_prio = 8'd1;
    core_wr(2'd2, 32'h7);

    // R4 readback and software flag
    core_wr(2'd1, 32'h0009_0000);
    chk_rd("R4 readback", 2'd1, 32'h0009_0000);
    chk_req("R4 flag no effect", 1'b0);

    // R5 pend without enable, cleared on take
    core_wr(2'd1, 32'h0002_0000);
    chk_rd("R5 pend readback", 2'd1, 32'h0002_0000);
    chk_req("R5 pend raises", 1'b1);
    pulse(3);
    chk_rd("R5 pend cleared", 2'd1, 32'h0);
    pulse(4);
    chk_req("R5 no req after return", 1'b0);

    // R10 handler masks request
    core_wr(2'd1, 32'h0001_0000);
    pulse(3);
    pulse(0);
    chk_stat("R10 bkpt in handler", 3'b010);
    chk_req("R10 masked", 1'b0);
    pulse(4);
    chk_req("R10 unmasked after return", 1'b1);
    core_wr(2'd2, 32'h7);

    // R9 single step
    pulse(2);
    chk_stat("R9 retire unarmed", 3'b000);
    pulse(3);
    core_wr(2'd1, 32'h0005_0000);
    pulse(2);
    chk_stat("R9 retire in handler", 3'b000);
    pulse(4);
    chk_req("R9 armed no req", 1'b0);
    chk_stat("R9 armed no status", 3'b000);
    pulse(2);
    chk_stat("R9 step done bit0", 3'b001);
    chk_req("R9 step req", 1'b1);
    pulse(3);
    core_wr(2'd2, 32'h1);
    core_wr(2'd1, 32'h0001_0000);
    pulse(4);
    pulse(2);
    chk_stat("R9 step disarmed", 3'b000);

    done = 1'b1;
    repeat (2) cyc();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule